// File: doc/BRIEF.md
# Static Memory Write Strobe Sequencer

This block runs one write access on an asynchronous static memory bus. A requester offers an address, write data and byte enables together with a timing plan. The timing plan gives a setup count and a pulse count for the write-enable strobe and for the chip-select strobe, plus a total cycle length, all in clock periods. The block captures the request and the plan, then drives the address, the byte selects and the data bus for the whole access. Each strobe goes low after its own setup count and stays low for its own pulse count.

A strobe's hold time is never programmed. It is whatever remains of the total cycle after that strobe's setup and pulse. When the programmed total is too short to hold a strobe's window, the total is stretched so that no hold is negative. When the two windows would not overlap, chip select is moved onto the write-enable start so that both strobes are low together. A ready/request handshake keeps a new access out until the current one has finished. A one-cycle done pulse marks the last cycle of each access.

Top module: `sram_wr_seq`

## Requirements
- R1: During reset and whenever the block is idle (ready high): chip select and write enable are high, the data output enable is low and done is low.
- R2: A request is accepted on a clock edge where req_i and ready_o are both high. From the next cycle, ready_o stays low until the access has ended.
- R3: Count the cycles of an access from 0, where cycle 0 is the first cycle after acceptance. Write enable is low exactly in cycles ws to ws+wp-1. Here ws is the write setup count and wp is the write pulse count, with a pulse count of 0 treated as 1.
- R4: Chip select is low exactly in cycles cs to cs+cp-1, with its own setup count cs and pulse count cp (0 treated as 1). It is independent of write enable whenever the two windows overlap.
- R5: The access lasts T cycles, where T is the largest of the programmed total, ws+wp and cs+cp. Each strobe's hold is therefore T minus its setup minus its pulse, and that hold may be zero.
- R6: The data output enable is high in every cycle of an access. Address, data and byte selects stay unchanged from cycle 0 through cycle T-1.
- R7: If the two low windows would not share a cycle, chip select uses the write-enable setup count as its start, keeping its own pulse count.
- R8: done_o is high for exactly one cycle, in cycle T-1. ready_o is high again in the cycle after.
- R9: Requests and changes to the address, data, byte enable or timing inputs while an access runs have no effect on that access.
- R10: Byte selects are active low: bit i of mem_bs_o is the inverse of captured byte enable bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Write request |
| ready_o | output | 1 | High when a request can be accepted |
| addr_i | input | ADDR_W | Write address |
| data_i | input | DATA_W | Write data |
| be_i | input | DATA_W/8 | Byte enables, active high |
| we_setup_i | input | CNT_W | Write-enable setup count |
| we_pulse_i | input | CNT_W | Write-enable pulse count |
| cs_setup_i | input | CNT_W | Chip-select setup count |
| cs_pulse_i | input | CNT_W | Chip-select pulse count |
| total_i | input | CNT_W | Programmed total cycle length |
| mem_addr_o | output | ADDR_W | Memory address lines |
| mem_data_o | output | DATA_W | Memory data output bus |
| mem_oe_o | output | 1 | Data bus output enable |
| mem_bs_o | output | DATA_W/8 | Byte selects, active low |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| done_o | output | 1 | High in the last cycle of an access |

## Verification
Two events can land in the same cycle. When a strobe has zero hold, its rising edge falls in the final cycle, together with the done pulse. A requester that keeps req_i high through an access also presents a new request in that same final cycle. The bench sweeps every combination of setup, pulse and total in a small configuration, so zero-hold cases for either strobe, and for both at once, all occur. It holds the request high with altered inputs until the final cycle. In each cycle it compares both strobes and done against windows computed arithmetically. It then confirms that the cycle after done is idle and that the perturbed inputs did not leak into the access.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;
   localparam int unsigned LEN_MAX_W = 16;

   typedef logic [LEN_MAX_W-1:0] len_t;

   typedef struct packed {
      len_t start;
      len_t stop;
   } win_t;

   typedef struct packed {
      win_t we;
      win_t cs;
      len_t total;
   } plan_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_BUSY = 1'b1
   } state_e;
endpackage

// File: rtl/sram_wr_plan.sv
module sram_wr_plan
   import sram_wr_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic [CNT_W-1:0] we_setup_i,
   input  logic [CNT_W-1:0] we_pulse_i,
   input  logic [CNT_W-1:0] cs_setup_i,
   input  logic [CNT_W-1:0] cs_pulse_i,
   input  logic [CNT_W-1:0] total_i,
   output plan_t            plan_o
);
   len_t we_beg, we_len, we_end;
   len_t cs_req, cs_len, cs_req_end, cs_beg, cs_end;
   len_t tot;
   logic overlap;

   always_comb begin
      // zero pulse counts are promoted to one cycle (R3, R4)
      we_len     = (we_pulse_i == '0) ? len_t'(1) : len_t'(we_pulse_i);
      cs_len     = (cs_pulse_i == '0) ? len_t'(1) : len_t'(cs_pulse_i);
      we_beg     = len_t'(we_setup_i);
      cs_req     = len_t'(cs_setup_i);
      we_end     = we_beg + we_len;
      cs_req_end = cs_req + cs_len;
      // windows share a cycle only if each starts before the other stops (R7)
      overlap    = (cs_req < we_end) && (we_beg < cs_req_end);
      cs_beg     = overlap ? cs_req : we_beg;
      cs_end     = cs_beg + cs_len;
      // stretch the total so no derived hold goes negative (R5)
      tot        = len_t'(total_i);
      if (we_end > tot) tot = we_end;
      if (cs_end > tot) tot = cs_end;
      plan_o.we.start = we_beg;
      plan_o.we.stop  = we_end;
      plan_o.cs.start = cs_beg;
      plan_o.cs.stop  = cs_end;
      plan_o.total    = tot;
   end
endmodule

// File: rtl/sram_wr_cycle.sv
module sram_wr_cycle
   import sram_wr_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  len_t tot_q_i,
   input  len_t tot_d_i,
   output logic busy_q_o,
   output logic busy_d_o,
   output len_t cnt_d_o,
   output logic last_d_o
);
   state_e st_q, st_d;
   len_t   cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      if (st_q == ST_IDLE) begin
         if (start_i) begin
            st_d  = ST_BUSY;
            cnt_d = '0;
         end
      end else if (cnt_q == tot_q_i - len_t'(1)) begin
         st_d  = ST_IDLE;
         cnt_d = '0;
      end else begin
         cnt_d = cnt_q + len_t'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign busy_q_o = (st_q == ST_BUSY);
   assign busy_d_o = (st_d == ST_BUSY);
   assign cnt_d_o  = cnt_d;
   assign last_d_o = (st_d == ST_BUSY) && (cnt_d == tot_d_i - len_t'(1));
endmodule

// File: rtl/sram_wr_strobe.sv
module sram_wr_strobe
   import sram_wr_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic act_i,
   input  len_t cnt_i,
   input  win_t win_i,
   output logic strobe_n_o
);
   logic low_d;

   assign low_d = act_i && (cnt_i >= win_i.start) && (cnt_i < win_i.stop);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) strobe_n_o <= 1'b1;
      else         strobe_n_o <= !low_d;
   end
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
   import sram_wr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 24,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CNT_W      = 4,
   parameter bit          BS_ACT_LOW = 1'b1,
   localparam int unsigned BE_W      = DATA_W / 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   output logic              ready_o,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [BE_W-1:0]   be_i,
   input  logic [CNT_W-1:0]  we_setup_i,
   input  logic [CNT_W-1:0]  we_pulse_i,
   input  logic [CNT_W-1:0]  cs_setup_i,
   input  logic [CNT_W-1:0]  cs_pulse_i,
   input  logic [CNT_W-1:0]  total_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_data_o,
   output logic              mem_oe_o,
   output logic [BE_W-1:0]   mem_bs_o,
   output logic              mem_cs_n_o,
   output logic              mem_we_n_o,
   output logic              done_o
);
   localparam int unsigned N_STROBE = 2;

   if (DATA_W % 8 != 0 || DATA_W == 0) begin : g_bad_data_w
      $error("sram_wr_seq: DATA_W must be a nonzero multiple of 8");
   end
   if (CNT_W + 1 > LEN_MAX_W || CNT_W == 0) begin : g_bad_cnt_w
      $error("sram_wr_seq: CNT_W out of range for internal length type");
   end
   if (ADDR_W == 0) begin : g_bad_addr_w
      $error("sram_wr_seq: ADDR_W must be nonzero");
   end

   plan_t plan_new, plan_q, plan_d;
   logic  busy_q, busy_d, last_d, accept;
   len_t  cnt_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [BE_W-1:0]   be_q;
   logic              oe_q, done_q;
   win_t              wins [N_STROBE];
   logic [N_STROBE-1:0] strobe_n;

   sram_wr_plan #(.CNT_W(CNT_W)) u_plan (
      .we_setup_i (we_setup_i),
      .we_pulse_i (we_pulse_i),
      .cs_setup_i (cs_setup_i),
      .cs_pulse_i (cs_pulse_i),
      .total_i    (total_i),
      .plan_o     (plan_new)
   );

   // new requests are taken only while idle (R2, R9)
   assign accept  = req_i && !busy_q;
   assign ready_o = !busy_q;
   assign plan_d  = accept ? plan_new : plan_q;

   sram_wr_cycle u_cycle (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (accept),
      .tot_q_i  (plan_q.total),
      .tot_d_i  (plan_d.total),
      .busy_q_o (busy_q),
      .busy_d_o (busy_d),
      .cnt_d_o  (cnt_d),
      .last_d_o (last_d)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         plan_q <= '0;
         addr_q <= '0;
         data_q <= '0;
         be_q   <= '0;
         oe_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         plan_q <= plan_d;
         oe_q   <= busy_d;
         done_q <= last_d;
         if (accept) begin
            addr_q <= addr_i;
            data_q <= data_i;
            be_q   <= be_i;
         end
      end
   end

   assign wins[0] = plan_d.we;
   assign wins[1] = plan_d.cs;

   for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
      sram_wr_strobe u_strobe (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .act_i      (busy_d),
         .cnt_i      (cnt_d),
         .win_i      (wins[g]),
         .strobe_n_o (strobe_n[g])
      );
   end

   if (BS_ACT_LOW) begin : g_bs_low
      assign mem_bs_o = ~be_q;
   end else begin : g_bs_high
      assign mem_bs_o = be_q;
   end

   assign mem_addr_o = addr_q;
   assign mem_data_o = data_q;
   assign mem_oe_o   = oe_q;
   assign mem_we_n_o = strobe_n[0];
   assign mem_cs_n_o = strobe_n[1];
   assign done_o     = done_q;
endmodule

// File: rtl/sram_wr_chk.sv
module sram_wr_chk #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned BE_W   = 2
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              req_i,
   input logic              ready_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [DATA_W-1:0] mem_data_o,
   input logic              mem_oe_o,
   input logic [BE_W-1:0]   mem_bs_o,
   input logic              mem_cs_n_o,
   input logic              mem_we_n_o,
   input logic              done_o
);
   logic both_seen_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         both_seen_q <= 1'b0;
      else if (done_o)                     both_seen_q <= 1'b0;
      else if (!mem_cs_n_o && !mem_we_n_o) both_seen_q <= 1'b1;
   end

   p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |-> (mem_cs_n_o && mem_we_n_o && !mem_oe_o && !done_o));

   p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && req_i) |=> !ready_o);

   p_we_in_access_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mem_we_n_o |-> !ready_o);

   p_cs_in_access_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mem_cs_n_o |-> !ready_o);

   p_oe_span_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_oe_o == !ready_o);

   p_bus_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ready_o && $past(!ready_o)) |->
         ($stable(mem_addr_o) && $stable(mem_data_o) && $stable(mem_bs_o)));

   p_overlap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (both_seen_q || (!mem_cs_n_o && !mem_we_n_o)));

   p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> (!done_o && ready_o));
endmodule

bind sram_wr_seq sram_wr_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .BE_W   (BE_W)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .req_i      (req_i),
   .ready_o    (ready_o),
   .mem_addr_o (mem_addr_o),
   .mem_data_o (mem_data_o),
   .mem_oe_o   (mem_oe_o),
   .mem_bs_o   (mem_bs_o),
   .mem_cs_n_o (mem_cs_n_o),
   .mem_we_n_o (mem_we_n_o),
   .done_o     (done_o)
);

// File: tb/sram_wr_seq_tb_top.sv
module sram_wr_seq_tb_top;
   localparam int AW = 10;
   localparam int DW = 16;
   localparam int CW = 2;
   localparam int BW = DW / 8;
   localparam int VMAX = (1 << CW);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req;
   logic          ready;
   logic [AW-1:0] addr;
   logic [DW-1:0] data;
   logic [BW-1:0] be;
   logic [CW-1:0] ws_i, wp_i, cs_i, cp_i, tot_i;
   logic [AW-1:0] m_addr;
   logic [DW-1:0] m_data;
   logic          m_oe;
   logic [BW-1:0] m_bs;
   logic          m_cs_n, m_we_n, done;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   sram_wr_seq #(
      .ADDR_W (AW), .DATA_W (DW), .CNT_W (CW), .BS_ACT_LOW (1'b1)
   ) dut_i (
      .clk_i (clk), .rst_ni (rst_n), .req_i (req), .ready_o (ready),
      .addr_i (addr), .data_i (data), .be_i (be),
      .we_setup_i (ws_i), .we_pulse_i (wp_i),
      .cs_setup_i (cs_i), .cs_pulse_i (cp_i), .total_i (tot_i),
      .mem_addr_o (m_addr), .mem_data_o (m_data), .mem_oe_o (m_oe),
      .mem_bs_o (m_bs), .mem_cs_n_o (m_cs_n), .mem_we_n_o (m_we_n),
      .done_o (done)
   );

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      req = 1'b0; addr = '0; data = '0; be = '0;
      ws_i = '0; wp_i = '0; cs_i = '0; cp_i = '0; tot_i = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 during reset
      chk(m_cs_n == 1'b1, "R1 cs_n in reset", m_cs_n, 1);
      chk(m_we_n == 1'b1, "R1 we_n in reset", m_we_n, 1);
      chk(m_oe == 1'b0 && done == 1'b0, "R1 oe/done in reset", {m_oe, done}, 0);
      chk(ready == 1'b1, "R1 ready in reset", ready, 1);
      rst_n = 1'b1;
      @(negedge clk);

      for (int ws = 0; ws < VMAX; ws++)
      for (int wp = 0; wp < VMAX; wp++)
      for (int cs = 0; cs < VMAX; cs++)
      for (int cp = 0; cp < VMAX; cp++)
      for (int tt = 0; tt < VMAX; tt++) begin
         int wpe, cpe, we_e, csb, cse, tot_e, idx;
         bit ovl;
         logic [AW-1:0] a_exp;
         logic [DW-1:0] d_exp;
         logic [BW-1:0] b_exp;
         idx   = (((ws * VMAX + wp) * VMAX + cs) * VMAX + cp) * VMAX + tt;
         wpe   = (wp == 0) ? 1 : wp;
         cpe   = (cp == 0) ? 1 : cp;
         we_e  = ws + wpe;
         ovl   = (cs < we_e) && (ws < cs + cpe);
         csb   = ovl ? cs : ws;
         cse   = csb + cpe;
         tot_e = tt;
         if (we_e > tot_e) tot_e = we_e;
         if (cse > tot_e) tot_e = cse;
         a_exp = AW'(idx * 3 + 1);
         d_exp = DW'(idx * 37 + 5);
         b_exp = BW'(idx);

         ws_i = CW'(ws); wp_i = CW'(wp); cs_i = CW'(cs); cp_i = CW'(cp); tot_i = CW'(tt);
         addr = a_exp; data = d_exp; be = b_exp; req = 1'b1;
         @(negedge clk);
         chk(ready == 1'b0, "R2 ready low after accept", ready, 0);

         for (int k = 0; k < tot_e; k++) begin
            bit we_low, cs_low;
            we_low = (k >= ws) && (k < we_e);
            cs_low = (k >= csb) && (k < cse);
            chk(m_we_n == !we_low, "R3 we_n window", m_we_n, !we_low);
            chk(m_cs_n == !cs_low, ovl ? "R4 cs_n window" : "R7 cs_n moved window",
                m_cs_n, !cs_low);
            chk(done == (k == tot_e - 1), "R5 R8 done at cycle T-1", done, (k == tot_e - 1));
            chk(m_oe == 1'b1, "R6 oe during access", m_oe, 1);
            chk(m_addr == a_exp && m_data == d_exp, "R6 R9 addr/data held",
                {m_addr, m_data}, {a_exp, d_exp});
            chk(m_bs == ~b_exp, "R10 byte selects active low", m_bs, ~b_exp);
            chk(ready == 1'b0, "R2 ready low while busy", ready, 0);
            if (k == tot_e - 1) begin
               req = 1'b0;
            end else begin
               // R9: keep requesting with altered inputs during the access
               addr = ~a_exp; data = ~d_exp; be = ~b_exp;
               ws_i = '1; wp_i = '1; cs_i = '0; cp_i = '1; tot_i = '1;
            end
            @(negedge clk);
         end
         chk(ready == 1'b1, "R8 ready after done", ready, 1);
         chk(m_cs_n && m_we_n && !m_oe && !done, "R1 idle strobes",
             {m_cs_n, m_we_n, m_oe, done}, 4'b1100);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule